// File: doc/BRIEF.md
# Peripheral Time Base Prescaler

This block makes the time-base ticks used by a group of timer, counter, capture and watchdog peripherals. A 4-bit down-counter advances once on each cycle where the system clock enable is high. When the counter is at zero the block emits a one-cycle tick, and the counter reloads from a programmable divide field. A field value of F therefore gives one tick every F+1 enabled cycles. Ratios from 1 to 16 are available. After reset the counter starts from 5, which gives the classic six-cycle spacing.

Each peripheral has its own output line. A mode input selects between two behaviours. In compatibility mode every line carries the prescaled tick. In fast mode each line carries the prescaled tick only when that peripheral's enable bit is set. Otherwise the line repeats the system clock enable, which is one tick per enabled cycle. The divide field may change at any time. The new value is used at the next reload, so a count already running is never cut short.

Top module: `tbase_prescaler`

## Requirements
- R1: While the synchronous reset is high, every tick line is 0, whatever the other inputs are.
- R2: Reset loads the counter with 5. With the enable held high, the first prescaled tick appears in the sixth cycle after reset is released. This holds for any divide field value.
- R3: With the divide field held at F (0 to 15), prescaled ticks after the first are exactly F+1 enabled cycles apart.
- R4: The counter advances only in cycles where the clock enable is 1. No prescaled tick is asserted in a cycle where the enable is 0.
- R5: A change to the divide field takes effect at the next reload. The count in progress completes with the old value.
- R6: When the mode input is 0 (compatibility), all tick lines carry the same prescaled tick and the enable bits have no effect.
- R7: When the mode input is 1 (fast) and enable bit i is 1, line i carries the prescaled tick.
- R8: When the mode input is 1 (fast) and enable bit i is 0, line i equals the clock enable in every cycle.
- R9: With a nonzero divide field, a prescaled tick lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | System clock enable; one enabled cycle per 1 |
| div_sel_i | input | CNT_W (4) | Divide field; ratio is value + 1 |
| fast_mode_i | input | 1 | 0 = compatibility mode, 1 = fast mode |
| pre_en_i | input | N_PERIPH (5) | Per-peripheral prescale enables, used in fast mode |
| tick_o | output | N_PERIPH (5) | Per-peripheral time-base tick |

## Verification
The bench overrides the peripheral count to 3 and keeps the 4-bit counter width. This keeps each routing pattern small enough to list every enable combination that matters. It also lets all 16 divide values be swept in one table. The 4-bit width puts the extreme ratios of 1 and 16 within reach of a run a few dozen cycles long. The three lines, combined with mixed enable patterns, cover prescaled and bypassed lines side by side in the same cycle.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic {
        TB_COMPAT = 1'b0,
        TB_FAST   = 1'b1
    } tb_mode_e;

    // Shared time base handed from the counter to the router.
    typedef struct packed {
        logic ce;    // enabled cycle, already quiet during reset
        logic tick;  // prescaled one-cycle pulse
    } tb_base_s;

    // A line follows the prescaled tick when the mode forces it or its enable asks for it.
    function automatic logic use_prescale(tb_mode_e mode, logic en);
        return (mode == TB_COMPAT) || en;
    endfunction

endpackage

// File: rtl/tbase_divcnt.sv
module tbase_divcnt
    import tbase_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int RESET_LOAD = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_i,
    input  logic [CNT_W-1:0] reload_i,
    output tb_base_s         base_o
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RESET_LOAD);
    localparam logic [CNT_W-1:0] ZERO     = '0;

    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= LOAD_VAL;
        end else if (ce_i) begin
            if (at_zero) cnt_q <= reload_i;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        base_o.ce   = ce_i & ~rst;
        base_o.tick = ce_i & ~rst & at_zero;
    end

endmodule

// File: rtl/tbase_route.sv
module tbase_route
    import tbase_pkg::*;
#(
    parameter int N_PERIPH = 5
) (
    input  tb_base_s            base_i,
    input  tb_mode_e            mode_i,
    input  logic [N_PERIPH-1:0] en_i,
    output logic [N_PERIPH-1:0] tick_o
);

    for (genvar g = 0; g < N_PERIPH; g++) begin : g_line
        always_comb begin
            if (use_prescale(mode_i, en_i[g])) tick_o[g] = base_i.tick;
            else                               tick_o[g] = base_i.ce;
        end
    end

endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
    import tbase_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int N_PERIPH   = 5,
    parameter int RESET_LOAD = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce_i,
    input  logic [CNT_W-1:0]    div_sel_i,
    input  logic                fast_mode_i,
    input  logic [N_PERIPH-1:0] pre_en_i,
    output logic [N_PERIPH-1:0] tick_o
);

    tb_base_s base;
    tb_mode_e mode;

    assign mode = fast_mode_i ? TB_FAST : TB_COMPAT;

    tbase_divcnt #(
        .CNT_W      (CNT_W),
        .RESET_LOAD (RESET_LOAD)
    ) u_divcnt (
        .clk      (clk),
        .rst      (rst),
        .ce_i     (ce_i),
        .reload_i (div_sel_i),
        .base_o   (base)
    );

    tbase_route #(
        .N_PERIPH (N_PERIPH)
    ) u_route (
        .base_i (base),
        .mode_i (mode),
        .en_i   (pre_en_i),
        .tick_o (tick_o)
    );

endmodule

// File: rtl/tbase_prescaler_chk.sv
module tbase_prescaler_chk #(
    parameter int CNT_W    = 4,
    parameter int N_PERIPH = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                ce_i,
    input logic [CNT_W-1:0]    div_sel_i,
    input logic                fast_mode_i,
    input logic [N_PERIPH-1:0] pre_en_i,
    input logic [N_PERIPH-1:0] tick_o
);

    // R1: lines stay quiet through reset
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |-> (tick_o == '0));

    // R4: no tick on a disabled cycle, in any mode
    a_r4_no_tick_without_ce: assert property (@(posedge clk) disable iff (rst)
        !ce_i |-> (tick_o == '0));

    // R6: compatibility mode drives every line identically
    a_r6_compat_uniform: assert property (@(posedge clk) disable iff (rst)
        !fast_mode_i |-> ($countones(tick_o) == 0 || $countones(tick_o) == N_PERIPH));

    // R9: nonzero field means the tick cannot repeat in the next cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (!fast_mode_i && tick_o[0] && div_sel_i != '0) |=> (fast_mode_i || !tick_o[0]));

    for (genvar g = 0; g < N_PERIPH; g++) begin : g_line
        // R8: bypassed line follows the enable
        a_r8_bypass_follows_ce: assert property (@(posedge clk) disable iff (rst)
            (fast_mode_i && !pre_en_i[g]) |-> (tick_o[g] == ce_i));
        // R7: a prescaled line in fast mode pulses no more often than the tick
        a_r7_fast_prescaled_single: assert property (@(posedge clk) disable iff (rst)
            (fast_mode_i && pre_en_i[g] && tick_o[g] && div_sel_i != '0)
                |=> (!(fast_mode_i && pre_en_i[g]) || !tick_o[g]));
    end

endmodule

bind tbase_prescaler tbase_prescaler_chk #(
    .CNT_W    (CNT_W),
    .N_PERIPH (N_PERIPH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ce_i        (ce_i),
    .div_sel_i   (div_sel_i),
    .fast_mode_i (fast_mode_i),
    .pre_en_i    (pre_en_i),
    .tick_o      (tick_o)
);

// File: tb/test_tbase_prescaler.sv
module test_tbase_prescaler;

    localparam int CW = 4;
    localparam int NP = 3;
    localparam int NV = 21;
    localparam int FIRST = 6;   // R2: reset load 5 -> tick in sixth cycle

    // vector: {fast[7], en[6:4], field[3:0]}
    localparam logic [7:0] VEC [NV] = '{
        8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77,
        8'h08, 8'h19, 8'h2A, 8'h3B, 8'h4C, 8'h5D, 8'h6E, 8'h7F,
        8'h85, 8'hF3, 8'hA0, 8'hDF, 8'hB7
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce = 1'b1;
    logic [CW-1:0] fld = '0;
    logic          fast = 1'b0;
    logic [NP-1:0] en = '0;
    logic [NP-1:0] tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tbase_prescaler #(.CNT_W(CW), .N_PERIPH(NP), .RESET_LOAD(5)) i_tbase_prescaler (
        .clk(clk), .rst(rst), .ce_i(ce), .div_sel_i(fld),
        .fast_mode_i(fast), .pre_en_i(en), .tick_o(tick)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    function automatic bit tick_at(int w, int p);
        return (w == FIRST) || (w > FIRST && ((w - FIRST) % p) == 0);
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        cyc();
        #1;
        check("R1", tick, '0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Table walk: R2, R3 (all 16 fields), R6, R7, R8, R9
        for (int v = 0; v < NV; v++) begin
            fast = VEC[v][7];
            en   = VEC[v][6:4];
            fld  = VEC[v][3:0];
            ce   = 1'b1;
            do_reset();
            for (int w = 1; w <= FIRST + 2 * (int'(fld) + 1); w++) begin
                logic [NP-1:0] exp;
                #1;
                for (int k = 0; k < NP; k++)
                    exp[k] = (!fast || en[k]) ? tick_at(w, int'(fld) + 1) : 1'b1;
                check(fast ? "R7/R8/R3" : "R2/R3/R6/R9", tick, exp);
                cyc();
            end
        end

        // R1: reset asserted mid-run in fast bypass must silence lines
        fast = 1'b1; en = '0; fld = 4'd2; ce = 1'b1;
        do_reset();
        #1;
        check("R8", tick, '1);
        rst = 1'b1;
        #1;
        check("R1", tick, '0);
        cyc();
        #1;
        check("R1", tick, '0);

        // R4: enable toggles; count only enabled cycles
        fast = 1'b0; en = '0; fld = 4'd1;
        do_reset();
        for (int w = 1; w <= 16; w++) begin
            ce = w[0];
            #1;
            check("R4", tick, (w == 11 || w == 15) ? '1 : '0);
            cyc();
        end

        // R8: bypassed lines mirror a toggling enable; R7 line stays prescaled
        fast = 1'b1; en = 3'b100; fld = 4'd0; ce = 1'b1;
        do_reset();
        for (int w = 1; w <= 12; w++) begin
            ce = (w % 3) != 0;
            #1;
            check("R8", tick[1:0], {2{ce}});
            cyc();
        end

        // R5: field change mid-count waits for the next reload
        fast = 1'b0; en = '0; fld = 4'd3; ce = 1'b1;
        do_reset();
        for (int w = 1; w <= 21; w++) begin
            if (w == 7) fld = 4'd9;
            #1;
            check("R5", tick, (w == 6 || w == 10 || w == 20) ? '1 : '0);
            cyc();
        end

        finish_run();
    end

endmodule